// File: doc/BRIEF.md
# Algebraic Right Shifter with Carry

This execution unit performs a signed (algebraic) right shift for a 64-bit integer pipeline. It has two widths of operation. In doubleword mode it shifts the full 64-bit source. In word mode it shifts only the low 32 bits and sign-extends the 32-bit result to 64 bits. The shift amount comes either from a register operand or from an immediate field carried in the instruction. Amounts larger than the operation width saturate, so the result is filled with the sign bit.

Besides the shifted value, the unit returns a carry flag. Carry is set only when the operand is negative and at least one 1-bit falls off the low end. When the record bit is set, the unit also updates a 4-bit condition field from a signed compare of the result with zero, together with the incoming summary-overflow bit. Each accepted operation appears on the registered outputs one cycle later, marked by an output-valid strobe.

Top module: `sra_carry_unit`

## Requirements
- R1: In doubleword mode (`word_mode`=0), `result` is `src` shifted right arithmetically by n, and vacated high bits copy `src[63]`.
- R2: `carry` is 1 only when the shifted operand is negative (bit 63 in doubleword mode, bit 31 in word mode) and at least one 1-bit is shifted out below bit 0. In every other case it is 0.
- R3: In doubleword mode an amount of 0 returns `src` unchanged with `carry`=0.
- R4: In doubleword mode an amount of 64 or more sets all 64 result bits to `src[63]` and sets `carry` to `src[63]`.
- R5: In word mode (`word_mode`=1) only `src[31:0]` is shifted, and the 32-bit result is sign-extended from its bit 31 into bits 63:32.
- R6: In word mode an amount of 0 returns `src[31:0]` sign-extended, with `carry`=0.
- R7: In word mode an amount of 32 or more sets all 64 result bits to `src[31]` and sets `carry` to `src[31]`.
- R8: When `use_imm`=1, the amount is {`imm_hi`,`imm_lo`} (6 bits) in doubleword mode and `imm_lo` alone in word mode, where `imm_hi` is ignored. `shift_reg` is ignored in both modes.
- R9: When `use_imm`=0, the amount is `shift_reg[6:0]` in doubleword mode and `shift_reg[5:0]` in word mode. Higher bits of `shift_reg` are ignored.
- R10: When `record`=1 on an accepted operation, `cond` becomes {LT,GT,EQ,SO} with bit 3 = result<0, bit 2 = result>0, bit 1 = result==0 (signed, 64-bit), and bit 0 = `so_in`.
- R11: When `record`=0, `cond` keeps its previous value.
- R12: The outputs update on the clock edge that samples `in_valid`=1, and `out_valid` is 1 for exactly that following cycle. `result` and `carry` hold their values when `in_valid`=0. A synchronous active-high `rst` clears `result`, `carry`, `cond` and `out_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation strobe |
| src | input | 64 | Source operand |
| shift_reg | input | 64 | Register shift-amount operand |
| imm_lo | input | 5 | Low five bits of the immediate amount |
| imm_hi | input | 1 | High bit of the immediate amount (doubleword only) |
| word_mode | input | 1 | 1 = word mode, 0 = doubleword mode |
| use_imm | input | 1 | 1 = amount from the immediate fields |
| record | input | 1 | Update the condition field |
| so_in | input | 1 | Current summary-overflow bit |
| out_valid | output | 1 | Registered result valid |
| result | output | 64 | Shifted result |
| carry | output | 1 | Carry flag |
| cond | output | 4 | Condition field {LT,GT,EQ,SO} |

## Verification
The hardest cases to reach are the ones where discarded amount bits could change the outcome. A register amount of 0x80 must act as a zero shift in doubleword mode. An amount of 0x40 must act as a zero shift in word mode. An immediate high bit must be ignored in word mode. The vector table places exactly these values in the amount inputs, so a decoder that reads one bit too many saturates and is caught. The carry cases are kept next to each other: negative operands with and without lost 1-bits, a positive operand that loses 1-bits, and saturated negative operands. This separates the sign term of the carry from the lost-bits term.

// File: rtl/sra_carry_unit.sv
module sra_carry_unit #(
  parameter int XLEN = 64
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic [XLEN-1:0]          src,
  input  logic [XLEN-1:0]          shift_reg,
  input  logic [$clog2(XLEN)-2:0]  imm_lo,
  input  logic                     imm_hi,
  input  logic                     word_mode,
  input  logic                     use_imm,
  input  logic                     record,
  input  logic                     so_in,
  output logic                     out_valid,
  output logic [XLEN-1:0]          result,
  output logic                     carry,
  output logic [3:0]               cond
);

  localparam int AW   = $clog2(XLEN);
  localparam int HALF = XLEN / 2;
  localparam logic [AW:0] FULL_AMT = XLEN[AW:0];
  localparam logic [AW:0] HALF_AMT = HALF[AW:0];

  logic [AW:0]      amt;
  logic [AW-1:0]    sh;
  logic             sat;
  logic [XLEN-1:0]  opnd;
  logic             sign;
  logic [XLEN-1:0]  shifted;
  logic [XLEN-1:0]  lost_mask;
  logic [XLEN-1:0]  res_n;
  logic             ca_n;
  logic             lt_n, eq_n, gt_n;
  logic             unused_hi;

  assign unused_hi = ^shift_reg[XLEN-1:AW+1];

  always_comb begin
    if (use_imm)
      amt = word_mode ? {2'b00, imm_lo} : {1'b0, imm_hi, imm_lo};
    else
      amt = word_mode ? {1'b0, shift_reg[AW-1:0]} : shift_reg[AW:0];
  end

  assign sat  = word_mode ? (amt >= HALF_AMT) : (amt >= FULL_AMT);
  assign sh   = word_mode ? {1'b0, amt[AW-2:0]} : amt[AW-1:0];
  assign opnd = word_mode ? {{HALF{src[HALF-1]}}, src[HALF-1:0]} : src;
  assign sign = opnd[XLEN-1];

  assign shifted   = $signed(opnd) >>> sh;
  assign lost_mask = sat ? {XLEN{1'b1}} : ((XLEN'(1) << sh) - XLEN'(1));

  assign res_n = sat ? {XLEN{sign}} : shifted;
  assign ca_n  = sign & (|(opnd & lost_mask));

  assign lt_n = res_n[XLEN-1];
  assign eq_n = (res_n == '0);
  assign gt_n = ~lt_n & ~eq_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      carry     <= 1'b0;
      cond      <= 4'b0000;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result <= res_n;
        carry  <= ca_n;
        if (record)
          cond <= {lt_n, gt_n, eq_n, so_in};
      end
    end
  end

endmodule

module sra_carry_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            word_mode,
  input logic            record,
  input logic            so_in,
  input logic            out_valid,
  input logic [XLEN-1:0] result,
  input logic            carry,
  input logic [3:0]      cond
);

  localparam int HALF = XLEN / 2;

  assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_hold_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(carry)));

  assert_carry_negative_R2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && carry) |-> result[XLEN-1]);

  assert_word_sext_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && word_mode) |=> (result[XLEN-1:HALF] == {HALF{result[HALF-1]}}));

  assert_cond_onehot_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && record) |=> ($countones(cond[3:1]) == 1));

  assert_cond_so_R10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && record) |=> (cond[0] == $past(so_in)));

  assert_cond_keep_R11: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && record) |=> $stable(cond));

endmodule

bind sra_carry_unit sra_carry_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .word_mode(word_mode),
  .record(record), .so_in(so_in), .out_valid(out_valid),
  .result(result), .carry(carry), .cond(cond)
);

// File: tb/sra_carry_unit_bench.sv
`timescale 1ns/1ps
module sra_carry_unit_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [63:0] src = '0;
  logic [63:0] shift_reg = '0;
  logic [4:0]  imm_lo = '0;
  logic        imm_hi = 1'b0;
  logic        word_mode = 1'b0;
  logic        use_imm = 1'b0;
  logic        record = 1'b0;
  logic        so_in = 1'b0;
  logic        out_valid;
  logic [63:0] result;
  logic        carry;
  logic [3:0]  cond;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  sra_carry_unit u_sra_carry_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .src(src), .shift_reg(shift_reg),
    .imm_lo(imm_lo), .imm_hi(imm_hi), .word_mode(word_mode), .use_imm(use_imm),
    .record(record), .so_in(so_in), .out_valid(out_valid), .result(result),
    .carry(carry), .cond(cond)
  );

  typedef struct packed {
    logic [63:0] v_src;
    logic [63:0] v_rsh;
    logic [5:0]  v_imm;
    logic        v_word;
    logic        v_useimm;
    logic [63:0] v_res;
    logic        v_ca;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    // R1 R2: negative, no 1-bits lost
    {64'h8000_0000_0000_0010, 64'd4,   6'd0,  1'b0, 1'b0, 64'hF800_0000_0000_0001, 1'b0},
    // R1 R2: negative, a 1-bit lost
    {64'h8000_0000_0000_0011, 64'd4,   6'd0,  1'b0, 1'b0, 64'hF800_0000_0000_0001, 1'b1},
    // R1 R2: positive, 1-bits lost
    {64'h7000_0000_0000_00FF, 64'd8,   6'd0,  1'b0, 1'b0, 64'h0070_0000_0000_0000, 1'b0},
    // R3
    {64'h8123_4567_89AB_CDEF, 64'd0,   6'd0,  1'b0, 1'b0, 64'h8123_4567_89AB_CDEF, 1'b0},
    // R4: 64
    {64'h8000_0000_0000_0000, 64'd64,  6'd0,  1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    // R4: 127
    {64'h7FFF_FFFF_FFFF_FFFF, 64'd127, 6'd0,  1'b0, 1'b0, 64'h0000_0000_0000_0000, 1'b0},
    // R9: bit 7 ignored in doubleword mode
    {64'hFFFF_0000_0000_0001, 64'h80,  6'd0,  1'b0, 1'b0, 64'hFFFF_0000_0000_0001, 1'b0},
    // R5 R2
    {64'h1234_5678_8000_0011, 64'd4,   6'd0,  1'b1, 1'b0, 64'hFFFF_FFFF_F800_0001, 1'b1},
    // R6
    {64'hAAAA_AAAA_8000_0000, 64'd0,   6'd0,  1'b1, 1'b0, 64'hFFFF_FFFF_8000_0000, 1'b0},
    // R7: 32
    {64'h0000_0000_8000_0000, 64'd32,  6'd0,  1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    // R7: 63
    {64'hFFFF_FFFF_7FFF_FFFF, 64'd63,  6'd0,  1'b1, 1'b0, 64'h0000_0000_0000_0000, 1'b0},
    // R9: bit 6 ignored in word mode
    {64'h0000_0000_7FFF_FFFF, 64'h40,  6'd0,  1'b1, 1'b0, 64'h0000_0000_7FFF_FFFF, 1'b0},
    // R8: immediate 32 in doubleword mode
    {64'hFFFF_FFFF_0000_0001, 64'd5,   6'd32, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1},
    // R8: immediate 63
    {64'h8000_0000_0000_0000, 64'd5,   6'd63, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},
    // R8: word mode ignores imm_hi (amount 3)
    {64'h0000_0000_0000_0040, 64'd5,   6'd35, 1'b1, 1'b1, 64'h0000_0000_0000_0008, 1'b0},
    // R2: positive low word loses a 1-bit
    {64'hFFFF_FFFF_0000_0003, 64'd1,   6'd0,  1'b1, 1'b0, 64'h0000_0000_0000_0001, 1'b0}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [63:0] s, input logic [63:0] r, input logic [5:0] im,
                     input logic w, input logic ui, input logic rec, input logic so);
    @(negedge clk);
    src = s; shift_reg = r; imm_hi = im[5]; imm_lo = im[4:0];
    word_mode = w; use_imm = ui; record = rec; so_in = so; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R12 watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset out_valid", {63'd0, out_valid}, 64'd0);
    check("R12 reset result", result, 64'd0);
    check("R12 reset carry", {63'd0, carry}, 64'd0);
    check("R12 reset cond", {60'd0, cond}, 64'd0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      run(v.v_src, v.v_rsh, v.v_imm, v.v_word, v.v_useimm, 1'b0, 1'b0);
      check($sformatf("R12 vec%0d out_valid", i), {63'd0, out_valid}, 64'd1);
      check($sformatf("R1-group vec%0d result", i), result, v.v_res);
      check($sformatf("R2 vec%0d carry", i), {63'd0, carry}, {63'd0, v.v_ca});
    end

    // R11: no record so far, cond still at its reset value
    check("R11 cond untouched by unrecorded ops", {60'd0, cond}, 64'd0);

    // R10 negative result with SO set
    run(64'h8000_0000_0000_0010, 64'd4, 6'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R10 cond negative", {60'd0, cond}, 64'h9);
    // R10 positive
    run(64'h0000_0000_0000_0100, 64'd4, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R10 cond positive", {60'd0, cond}, 64'h4);
    // R10 zero
    run(64'h0000_0000_0000_000F, 64'd4, 6'd0, 1'b0, 1'b0, 1'b1, 1'b0);
    check("R10 cond zero", {60'd0, cond}, 64'h2);
    check("R10 zero result", result, 64'd0);
    // R11 record clear keeps cond
    run(64'h8000_0000_0000_0000, 64'd1, 6'd0, 1'b0, 1'b0, 1'b0, 1'b1);
    check("R11 cond kept", {60'd0, cond}, 64'h2);
    check("R1 result before hold", result, 64'hC000_0000_0000_0000);

    // R12 hold while idle
    @(negedge clk);
    src = 64'h1; shift_reg = 64'd0;
    @(negedge clk);
    check("R12 out_valid low when idle", {63'd0, out_valid}, 64'd0);
    check("R12 result held", result, 64'hC000_0000_0000_0000);

    // R12 reset mid-run
    run(64'h8000_0000_0000_0001, 64'd1, 6'd0, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R2 carry before reset", {63'd0, carry}, 64'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R12 reset clears result", result, 64'd0);
    check("R12 reset clears carry", {63'd0, carry}, 64'd0);
    check("R12 reset clears cond", {60'd0, cond}, 64'd0);
    rst = 1'b0;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule